// File: doc/BRIEF.md
# Decoupled Access/Execute Queue Interface

This block sits between an access engine, which computes addresses and fetches operands, and a compute engine, which does only arithmetic. Operands fetched by the access engine travel to the compute engine through a load queue. The compute engine reads the load queue head as an operand source. Each load entry carries a one-bit tag. A tagged entry is an end-of-data marker. It raises a branch-test flag instead of handing over a data word, and the compute engine uses that flag to leave its loop.

Stores are split across the two engines. The access engine pushes store addresses into one queue and the compute engine pushes store values into another. A small pairing state machine waits until both queue heads exist, pops them together and presents one memory write. That write is held until the memory accepts it. The Nth address therefore always meets the Nth value.

The pairing machine has two states. PAIR_IDLE holds no write. Its transition IDLE_TO_ISSUE fires when both store queues are non-empty. PAIR_ISSUE presents a write and has three transitions. ISSUE_HOLD keeps the write while the memory is not ready. ISSUE_NEXT reloads the next pair on acceptance when both queues still hold entries. ISSUE_TO_IDLE returns to PAIR_IDLE on acceptance when either queue is empty.

Top module: `daq_top`

## Requirements
- R1: After reset all three queues are empty: the empty flags are 1, the full flags are 0, `ld_head_eod` is 0 and `mem_wr_valid` is 0.
- R2: The load queue delivers its data words in push order. While `ld_empty` is 0, `ld_head_data` shows the oldest entry. A pop consumes the head at the next rising clock edge.
- R3: A load push with `ld_push_eod`=1 stores an end-of-data marker. When the marker reaches the head, `ld_head_eod` is 1 and `ld_head_data` reads 0. A pop removes the marker like any other entry.
- R4: The load queue raises `ld_full` when it holds 8 entries. A push while full, with no pop in the same cycle, is not stored, and the entries already held are unchanged.
- R5: A load pop while `ld_empty` is 1 has no effect. No entry is lost or duplicated, and the next pushed value is the next value delivered.
- R6: On a full load queue, a push and a pop in the same cycle are both taken. The queue stays full and the pushed value becomes the newest entry.
- R7: A memory write is presented only after both store queues have held an entry. Writes pair the store addresses and store values strictly in their separate push orders.
- R8: While `mem_wr_valid` is 1 and `mem_wr_ready` is 0, the write stays valid and its address and data do not change.
- R9: Each store queue raises its full flag at 8 entries and reports empty when it holds none. A push into a full store queue that is not draining is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_push | input | 1 | Access engine pushes a load entry |
| ld_push_eod | input | 1 | The pushed entry is an end-of-data marker |
| ld_push_data | input | 32 | Operand word to push |
| ld_full | output | 1 | Load queue holds 8 entries |
| ld_pop | input | 1 | Compute engine consumes the load head |
| ld_empty | output | 1 | Load queue holds no entry |
| ld_head_data | output | 32 | Operand at the load head (0 for a marker) |
| ld_head_eod | output | 1 | Branch-test flag: the load head is a marker |
| sa_push | input | 1 | Access engine pushes a store address |
| sa_addr | input | 32 | Store address to push |
| sa_full | output | 1 | Store address queue holds 8 entries |
| sa_empty | output | 1 | Store address queue holds no entry |
| sd_push | input | 1 | Compute engine pushes a store value |
| sd_data | input | 32 | Store value to push |
| sd_full | output | 1 | Store data queue holds 8 entries |
| sd_empty | output | 1 | Store data queue holds no entry |
| mem_wr_valid | output | 1 | A paired memory write is presented |
| mem_wr_addr | output | 32 | Address of the presented write |
| mem_wr_data | output | 32 | Data of the presented write |
| mem_wr_ready | input | 1 | Memory accepts the presented write |

## Verification
The hardest condition to reach is a store address queue that is full while the data queue is empty and the memory is stalled. This is the only state in which an extra address is refused with no write in flight to mask it. The stimulus holds `mem_wr_ready` low, pushes nine addresses with no values, and then releases values a few at a time before reopening the memory. Separate random runs vary push rates and ready toggling on the store side. They also vary push and pop mixes on the load side, with markers sprinkled in, so that simultaneous push and pop on a full queue comes up repeatedly.

// File: rtl/daq_pkg.sv
package daq_pkg;
    typedef enum logic [0:0] {
        PAIR_IDLE  = 1'b0,
        PAIR_ISSUE = 1'b1
    } pair_state_e;

    localparam int unsigned DAQ_DEPTH  = 8;
    localparam int unsigned DAQ_DATA_W = 32;
    localparam int unsigned DAQ_ADDR_W = 32;
endpackage

// File: rtl/daq_fifo.sv
module daq_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_word,
    input  logic             pop,
    output logic [WIDTH-1:0] head_word,
    output logic             full,
    output logic             empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    count_q;
    logic             pop_ok, push_ok;

    assign empty   = (count_q == '0);
    assign full    = (count_q == FULL_CNT);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign head_word = mem_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr_q <= (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[wr_ptr_q] <= push_word;
        end
    end
endmodule

// File: rtl/daq_store_pair.sv
module daq_store_pair
    import daq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_empty,
    input  logic [ADDR_W-1:0] addr_head,
    input  logic              data_empty,
    input  logic [DATA_W-1:0] data_head,
    output logic              pop_both,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready
);
    pair_state_e state_q, state_d;
    logic        both_avail;

    assign both_avail = !addr_empty && !data_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PAIR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        pop_both = 1'b0;
        wr_valid = 1'b0;
        unique case (state_q)
            PAIR_IDLE: begin
                if (both_avail) begin
                    pop_both = 1'b1;
                    state_d  = PAIR_ISSUE;
                end
            end
            PAIR_ISSUE: begin
                wr_valid = 1'b1;
                if (wr_ready) begin
                    if (both_avail) begin
                        pop_both = 1'b1;
                    end else begin
                        state_d = PAIR_IDLE;
                    end
                end
            end
            default: state_d = PAIR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (pop_both) begin
            wr_addr <= addr_head;
            wr_data <= data_head;
        end
    end
endmodule

// File: rtl/daq_top.sv
module daq_top
    import daq_pkg::*;
#(
    parameter int unsigned DEPTH  = DAQ_DEPTH,
    parameter int unsigned DATA_W = DAQ_DATA_W,
    parameter int unsigned ADDR_W = DAQ_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_push,
    input  logic              ld_push_eod,
    input  logic [DATA_W-1:0] ld_push_data,
    output logic              ld_full,
    input  logic              ld_pop,
    output logic              ld_empty,
    output logic [DATA_W-1:0] ld_head_data,
    output logic              ld_head_eod,
    input  logic              sa_push,
    input  logic [ADDR_W-1:0] sa_addr,
    output logic              sa_full,
    output logic              sa_empty,
    input  logic              sd_push,
    input  logic [DATA_W-1:0] sd_data,
    output logic              sd_full,
    output logic              sd_empty,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready
);
    localparam int unsigned LD_W = DATA_W + 1;

    logic [LD_W-1:0]   ld_head_word;
    logic [ADDR_W-1:0] sa_head;
    logic [DATA_W-1:0] sd_head;
    logic              pair_pop;

    daq_fifo #(.DEPTH(DEPTH), .WIDTH(LD_W)) u_ld_q (
        .clk(clk), .rst_n(rst_n),
        .push(ld_push), .push_word({ld_push_eod, ld_push_data}),
        .pop(ld_pop), .head_word(ld_head_word),
        .full(ld_full), .empty(ld_empty)
    );

    assign ld_head_eod  = !ld_empty && ld_head_word[LD_W-1];
    assign ld_head_data = (ld_empty || ld_head_word[LD_W-1]) ? '0 : ld_head_word[DATA_W-1:0];

    daq_fifo #(.DEPTH(DEPTH), .WIDTH(ADDR_W)) u_sa_q (
        .clk(clk), .rst_n(rst_n),
        .push(sa_push), .push_word(sa_addr),
        .pop(pair_pop), .head_word(sa_head),
        .full(sa_full), .empty(sa_empty)
    );

    daq_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_sd_q (
        .clk(clk), .rst_n(rst_n),
        .push(sd_push), .push_word(sd_data),
        .pop(pair_pop), .head_word(sd_head),
        .full(sd_full), .empty(sd_empty)
    );

    daq_store_pair #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pair (
        .clk(clk), .rst_n(rst_n),
        .addr_empty(sa_empty), .addr_head(sa_head),
        .data_empty(sd_empty), .data_head(sd_head),
        .pop_both(pair_pop),
        .wr_valid(mem_wr_valid), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
        .wr_ready(mem_wr_ready)
    );
endmodule

// File: rtl/daq_checker.sv
module daq_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_full,
    input logic              ld_empty,
    input logic [DATA_W-1:0] ld_head_data,
    input logic              ld_head_eod,
    input logic              sa_full,
    input logic              sa_empty,
    input logic              sd_full,
    input logic              sd_empty,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic              mem_wr_ready
);
    AST_LD_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_full && ld_empty)); // R4
    AST_EOD_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ld_head_eod |-> (!ld_empty && ld_head_data == '0)); // R3
    AST_ST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sa_full && sa_empty) && !(sd_full && sd_empty)); // R9
    AST_WR_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> $past(!sa_empty && !sd_empty)); // R7
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R8
endmodule

bind daq_top daq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_daq_checker (
    .clk(clk), .rst_n(rst_n),
    .ld_full(ld_full), .ld_empty(ld_empty),
    .ld_head_data(ld_head_data), .ld_head_eod(ld_head_eod),
    .sa_full(sa_full), .sa_empty(sa_empty),
    .sd_full(sd_full), .sd_empty(sd_empty),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready)
);

// File: tb/daq_top_tb.sv
module daq_top_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_push, ld_push_eod, ld_pop;
    logic [31:0] ld_push_data;
    logic        ld_full, ld_empty, ld_head_eod;
    logic [31:0] ld_head_data;
    logic        sa_push, sd_push, mem_wr_ready;
    logic [31:0] sa_addr, sd_data;
    logic        sa_full, sa_empty, sd_full, sd_empty, mem_wr_valid;
    logic [31:0] mem_wr_addr, mem_wr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [32:0] lq[$];
    logic [31:0] qa[$];
    logic [31:0] qd[$];
    int          writes_seen = 0;
    bit          prev_stall = 1'b0;
    logic [31:0] prev_addr, prev_data;

    always #2 clk = ~clk;

    daq_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .ld_push(ld_push), .ld_push_eod(ld_push_eod), .ld_push_data(ld_push_data),
        .ld_full(ld_full), .ld_pop(ld_pop), .ld_empty(ld_empty),
        .ld_head_data(ld_head_data), .ld_head_eod(ld_head_eod),
        .sa_push(sa_push), .sa_addr(sa_addr), .sa_full(sa_full), .sa_empty(sa_empty),
        .sd_push(sd_push), .sd_data(sd_data), .sd_full(sd_full), .sd_empty(sd_empty),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit ld_push_taken(input bit push, input bit pop_eff, input int size);
        return push && (size < DEPTH || pop_eff);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One load-side cycle: compare outputs with the model, drive, update model.
    task automatic ld_cycle(input bit push, input bit eod, input logic [31:0] d, input bit pop, input string req);
        bit pop_eff;
        check(ld_empty == (lq.size() == 0), {req, " empty"}, ld_empty, lq.size() == 0);
        check(ld_full == (lq.size() == DEPTH), {req, " R4 full"}, ld_full, lq.size() == DEPTH);
        if (lq.size() != 0) begin
            check(ld_head_eod == lq[0][32], {req, " R3 eod"}, ld_head_eod, lq[0][32]);
            check(ld_head_data == (lq[0][32] ? 32'h0 : lq[0][31:0]), {req, " R2 data"},
                  ld_head_data, lq[0][32] ? 32'h0 : lq[0][31:0]);
        end
        ld_push = push; ld_push_eod = eod; ld_push_data = d; ld_pop = pop;
        pop_eff = pop && (lq.size() != 0);
        if (pop_eff) void'(lq.pop_front());
        if (ld_push_taken(push, pop_eff, lq.size() + (pop_eff ? 1 : 0))) lq.push_back({eod, d});
        step();
        ld_push = 0; ld_pop = 0;
    endtask

    task automatic st_cycle(input bit ap, input logic [31:0] a, input bit dp, input logic [31:0] d, input bit rdy);
        sa_push = ap; sa_addr = a; sd_push = dp; sd_data = d; mem_wr_ready = rdy;
        if (prev_stall) begin
            check(mem_wr_valid && mem_wr_addr == prev_addr && mem_wr_data == prev_data,
                  "R8 hold", {mem_wr_addr, mem_wr_data}, {prev_addr, prev_data});
        end
        if (mem_wr_valid && rdy) begin
            writes_seen++;
            if (qa.size() == 0 || qd.size() == 0) begin
                check(1'b0, "R7 write without pair", writes_seen, 0);
            end else begin
                check(mem_wr_addr == qa[0] && mem_wr_data == qd[0], "R7 pair order",
                      {mem_wr_addr, mem_wr_data}, {qa[0], qd[0]});
                void'(qa.pop_front()); void'(qd.pop_front());
            end
        end
        prev_stall = mem_wr_valid && !rdy;
        prev_addr = mem_wr_addr; prev_data = mem_wr_data;
        if (ap && !sa_full) qa.push_back(a);
        if (dp && !sd_full) qd.push_back(d);
        step();
        sa_push = 0; sd_push = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 0; ld_push = 0; ld_push_eod = 0; ld_push_data = 0; ld_pop = 0;
        sa_push = 0; sa_addr = 0; sd_push = 0; sd_data = 0; mem_wr_ready = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        check(ld_empty && !ld_full && !ld_head_eod, "R1 load reset", {ld_empty, ld_full, ld_head_eod}, 3'b100);
        check(sa_empty && !sa_full && sd_empty && !sd_full, "R1 store reset",
              {sa_empty, sa_full, sd_empty, sd_full}, 4'b1010);
        check(!mem_wr_valid, "R1 no write", mem_wr_valid, 0);

        // R2/R4: fill, overfill, drain
        for (int i = 0; i < DEPTH; i++) ld_cycle(1, 0, 32'hA000 + i, 0, "R2 fill");
        check(ld_full, "R4 full at depth", ld_full, 1);
        ld_cycle(1, 0, 32'hDEAD, 0, "R4 overfill");
        for (int i = 0; i < DEPTH; i++) ld_cycle(0, 0, 0, 1, "R4 drain");
        check(ld_empty, "R4 drained", ld_empty, 1);
        // R5: pops on empty, then one push
        ld_cycle(0, 0, 0, 1, "R5 empty pop");
        ld_cycle(0, 0, 0, 1, "R5 empty pop");
        ld_cycle(1, 0, 32'h5555, 0, "R5 push");
        check(!ld_empty && ld_head_data == 32'h5555, "R5 next value", ld_head_data, 32'h5555);
        ld_cycle(0, 0, 0, 1, "R5 pop");
        check(ld_empty, "R5 no duplicate", ld_empty, 1);

        // R3: marker between data words
        ld_cycle(1, 0, 32'h11, 0, "R3 push");
        ld_cycle(1, 1, 32'hFFFF, 0, "R3 marker");
        ld_cycle(1, 0, 32'h22, 0, "R3 push");
        ld_cycle(0, 0, 0, 1, "R3 pop");
        check(ld_head_eod && ld_head_data == 0, "R3 marker at head", {ld_head_eod, ld_head_data}, {1'b1, 32'h0});
        ld_cycle(0, 0, 0, 1, "R3 pop marker");
        check(!ld_head_eod && ld_head_data == 32'h22, "R3 after marker", ld_head_data, 32'h22);
        ld_cycle(0, 0, 0, 1, "R3 pop");

        // R6: push and pop on a full queue
        for (int i = 0; i < DEPTH; i++) ld_cycle(1, 0, 32'hB000 + i, 0, "R6 fill");
        ld_cycle(1, 0, 32'hC0DE, 1, "R6 both");
        check(ld_full && ld_head_data == 32'hB001, "R6 stays full", {ld_full, ld_head_data}, {1'b1, 32'hB001});
        for (int i = 0; i < DEPTH; i++) ld_cycle(0, 0, 0, 1, "R6 drain");

        // Random load traffic with markers
        for (int i = 0; i < 600; i++)
            ld_cycle(($urandom % 3) != 0, ($urandom % 7) == 0, $urandom, ($urandom % 2) == 0, "R2 random");
        while (lq.size() != 0) ld_cycle(0, 0, 0, 1, "R2 flush");

        // R9/R7: addresses only, memory stalled
        for (int i = 0; i < DEPTH + 1; i++) begin
            st_cycle(1, 32'h1000 + i, 0, 0, 0);
            check(!mem_wr_valid, "R7 no write without data", mem_wr_valid, 0);
        end
        check(sa_full && !sa_empty && sd_empty, "R9 addr queue full", {sa_full, sa_empty, sd_empty}, 3'b101);
        for (int i = 0; i < 3; i++) st_cycle(0, 0, 1, 32'h9000 + i, 0);
        check(mem_wr_valid, "R7 write after pair", mem_wr_valid, 1);
        st_cycle(0, 0, 0, 0, 0);
        for (int i = 3; i < DEPTH + 1; i++) st_cycle(0, 0, 1, 32'h9000 + i, 1);
        for (int i = 0; i < 20; i++) st_cycle(0, 0, 0, 0, 1);
        check(writes_seen == DEPTH && qa.size() == 0, "R9 overfill address dropped", writes_seen, DEPTH);
        check(qd.size() == 1 && !sd_empty && !mem_wr_valid, "R9 leftover data", qd.size(), 1);
        for (int i = 0; i < DEPTH; i++) st_cycle(1, 32'h7000 + i, 1, 32'h6000 + i, 1);
        for (int i = 0; i < 20; i++) st_cycle(0, 0, 0, 0, 1);
        check(qa.size() == 0 && qd.size() == 1, "R7 offset pairing drained", qa.size(), 0);
        check(!sa_full && !sd_full, "R9 not full after drain", {sa_full, sd_full}, 2'b00);

        // Random store traffic
        for (int i = 0; i < 800; i++)
            st_cycle(($urandom % 2) == 0 && !sa_full, $urandom, ($urandom % 2) == 0 && !sd_full, $urandom,
                     ($urandom % 3) != 0);
        for (int i = 0; i < 40; i++) st_cycle(0, 0, 0, 0, 1);
        check(qa.size() == 0 || qd.size() == 0, "R7 all pairs written", qa.size() * qd.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule